// File: doc/BRIEF.md
# Probabilistic Chromosome Mutation Unit

This block mutates one offspring chromosome per request in an evolutionary search pipeline. A caller presents a chromosome, a two-bit method code and a mutation threshold, then pulses `start` while `ready` is high. The unit picks one of three methods at run time: invert a single bit at a random index, XOR the whole word with a random mask, or invert each bit whose own random draw falls at or below the threshold. A fourth code passes the chromosome through untouched.

Every mutation is gated by a probability test. A random value `pr`, as wide as the threshold, is drawn for each request. Mutation happens only when `pr` is less than or equal to the threshold; otherwise the chromosome comes back unchanged. Two internal Galois shift registers supply the random values. The first holds the bit index. The second is as wide as the chromosome plus the threshold, and it supplies the mask, the `pr` value and the per-bit draws. Both registers step exactly once for each accepted request.

Top module: `chrom_mutator`

## Requirements
- R1: While reset is applied and after it is released, `ready` is 1 and `chrom_out` is all zeros until the first request is accepted.
- R2: A `start` seen with `ready` high is accepted. At that clock edge the result is written to `chrom_out`, and `ready` drops to 0 for exactly one cycle. A `start` seen while `ready` is low is ignored: the output and the random state stay unchanged.
- R3: Method codes on `mut_mode` are 2'b00 single-bit, 2'b01 masked, 2'b10 uniform and 2'b11 copy. Copy always returns the input unchanged.
- R4: Let S be the wide register state at acceptance. Then `pr` is S[CHROM_W+PROB_W-1:CHROM_W]. When `pr` is greater than `mut_prob`, the result equals `chrom_in` for every method.
- R5: Single-bit method: when the gate passes, exactly one bit is inverted. That bit's index is P mod CHROM_W, where P is the point register state at acceptance.
- R6: Masked method: when the gate passes, the result is `chrom_in` XOR S[CHROM_W-1:0].
- R7: Uniform method: when the gate passes, bit i is inverted exactly when the PROB_W-bit window of {S,S} that starts at bit i is less than or equal to `mut_prob`.
- R8: On reset the wide register loads 24'hACE1F5 and the point register loads 8'h5A (default widths). Each accepted request steps each register once. The step is s' = (s >> 1) XOR (s[0] ? POLY : 0), with POLY = 24'hE10000 for the wide register and 8'hB8 for the point register. The values used by a request are the states held before its step.
- R9: With `mut_prob` all ones the gate always passes, and the uniform method inverts every bit.
- R10: With `mut_prob` zero, mutation happens only for requests whose `pr` is exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, taken when `ready` is high |
| mut_mode | input | 2 | Method code (see R3) |
| mut_prob | input | PROB_W | Mutation threshold compared against random draws |
| chrom_in | input | CHROM_W | Offspring chromosome to mutate |
| chrom_out | output | CHROM_W | Registered mutated chromosome |
| ready | output | 1 | High when a new request can be taken |

## Verification
Two things can fall in the same clock edge: a request being registered, and a second `start` arriving in the settle cycle that follows it. The bench holds `start` high across several edges and changes the chromosome between them. The first request must be registered, the edge with `ready` low must leave the output and the random state untouched, and the next edge must be taken with random values stepped only once. A bench-side model of both shift registers predicts every result. The gate is probed at its boundaries, with the threshold at zero and at all ones.

// File: rtl/chrom_mut_pkg.sv
package chrom_mut_pkg;
  typedef enum logic [1:0] {
    MUT_SINGLE  = 2'b00,
    MUT_MASK    = 2'b01,
    MUT_UNIFORM = 2'b10,
    MUT_COPY    = 2'b11
  } mut_mode_e;

  typedef enum logic {
    CT_IDLE   = 1'b0,
    CT_SETTLE = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/chrom_mut_lfsr.sv
module chrom_mut_lfsr #(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    POLY = 'hB8,
  parameter logic [W-1:0]    SEED = 'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (step) begin
      state_d = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));
endmodule

// File: rtl/chrom_mut_ctrl.sv
module chrom_mut_ctrl
  import chrom_mut_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready,
  output logic accept
);
  ctrl_state_e st_q;
  ctrl_state_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      CT_IDLE:   if (start) st_d = CT_SETTLE;
      CT_SETTLE: st_d = CT_IDLE;
      default:   st_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CT_IDLE;
    else        st_q <= st_d;
  end

  assign ready  = (st_q == CT_IDLE);
  assign accept = ready && start;

  // R2
  take_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready);

  // R2
  settle_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);
endmodule

// File: rtl/chrom_mut_core.sv
module chrom_mut_core
  import chrom_mut_pkg::*;
#(
  parameter int unsigned CHROM_W = 16,
  parameter int unsigned PROB_W  = 8,
  parameter int unsigned PT_W    = 8,
  localparam int unsigned SW     = CHROM_W + PROB_W,
  localparam int unsigned IDX_W  = (CHROM_W > 1) ? $clog2(CHROM_W) : 1
) (
  input  logic [CHROM_W-1:0] chrom_in,
  input  mut_mode_e          mode,
  input  logic [PROB_W-1:0]  pm,
  input  logic [SW-1:0]      mask_state,
  input  logic [PT_W-1:0]    point_state,
  output logic               gate_pass,
  output logic [CHROM_W-1:0] result
);
  logic [PROB_W-1:0]  pr;
  logic [IDX_W-1:0]   pt_idx;
  logic [CHROM_W-1:0] single_flip;
  logic [CHROM_W-1:0] uni_flip;
  logic [CHROM_W-1:0] sel_flip;
  logic [2*SW-1:0]    dbl;

  assign pr        = mask_state[SW-1:CHROM_W];
  assign gate_pass = (pr <= pm);
  assign pt_idx    = IDX_W'(32'(point_state) % CHROM_W);
  assign dbl       = {mask_state, mask_state};

  always_comb begin
    single_flip         = '0;
    single_flip[pt_idx] = 1'b1;
  end

  for (genvar i = 0; i < CHROM_W; i++) begin : g_uni
    logic [PROB_W-1:0] win;
    assign win         = dbl[i +: PROB_W];
    assign uni_flip[i] = (win <= pm);
  end

  always_comb begin
    case (mode)
      MUT_SINGLE:  sel_flip = single_flip;
      MUT_MASK:    sel_flip = mask_state[CHROM_W-1:0];
      MUT_UNIFORM: sel_flip = uni_flip;
      default:     sel_flip = '0;
    endcase
    result = gate_pass ? (chrom_in ^ sel_flip) : chrom_in;
  end
endmodule

// File: rtl/chrom_mutator.sv
module chrom_mutator
  import chrom_mut_pkg::*;
#(
  parameter int unsigned CHROM_W = 16,
  parameter int unsigned PROB_W  = 8,
  localparam int unsigned SW     = CHROM_W + PROB_W,
  localparam int unsigned PT_W   = 2 * ((CHROM_W > 1) ? $clog2(CHROM_W) : 1),
  parameter logic [SW-1:0]   MASK_POLY  = 'hE10000,
  parameter logic [SW-1:0]   MASK_SEED  = 'hACE1F5,
  parameter logic [PT_W-1:0] POINT_POLY = 'hB8,
  parameter logic [PT_W-1:0] POINT_SEED = 'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mut_mode,
  input  logic [PROB_W-1:0]  mut_prob,
  input  logic [CHROM_W-1:0] chrom_in,
  output logic [CHROM_W-1:0] chrom_out,
  output logic               ready
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               accept;
  logic               gate_pass;
  logic [SW-1:0]      mask_state;
  logic [PT_W-1:0]    point_state;
  logic [CHROM_W-1:0] result;
  logic [CHROM_W-1:0] out_q;
  logic [CHROM_W-1:0] out_d;
  mut_mode_e          mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode = mut_mode_e'(mut_mode);

  chrom_mut_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .ready  (ready),
    .accept (accept)
  );

  chrom_mut_lfsr #(.W(SW), .POLY(MASK_POLY), .SEED(MASK_SEED)) u_mask_rng (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (accept),
    .state (mask_state)
  );

  chrom_mut_lfsr #(.W(PT_W), .POLY(POINT_POLY), .SEED(POINT_SEED)) u_point_rng (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (accept),
    .state (point_state)
  );

  chrom_mut_core #(.CHROM_W(CHROM_W), .PROB_W(PROB_W), .PT_W(PT_W)) u_core (
    .chrom_in    (chrom_in),
    .mode        (mode),
    .pm          (mut_prob),
    .mask_state  (mask_state),
    .point_state (point_state),
    .gate_pass   (gate_pass),
    .result      (result)
  );

  always_comb begin
    out_d = out_q;
    if (accept) out_d = result;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_q <= '0;
    else            out_q <= out_d;
  end

  assign chrom_out = out_q;

  // R4
  gate_fail_copy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !gate_pass) |=> (chrom_out == $past(chrom_in)));

  // R3
  copy_mode_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && mode == MUT_COPY) |=> (chrom_out == $past(chrom_in)));

  // R5
  single_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && gate_pass && mode == MUT_SINGLE)
      |=> ($countones(chrom_out ^ $past(chrom_in)) == 1));

  // R2
  idle_out_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !accept |=> $stable(chrom_out));
endmodule

// File: tb/chrom_mutator_bench.sv
module chrom_mutator_bench;
  localparam int unsigned CW = 16;
  localparam int unsigned PW = 8;
  localparam int unsigned SW = CW + PW;
  localparam int unsigned TW = 8;
  localparam logic [SW-1:0] MPOLY = 24'hE10000;
  localparam logic [SW-1:0] MSEED = 24'hACE1F5;
  localparam logic [TW-1:0] TPOLY = 8'hB8;
  localparam logic [TW-1:0] TSEED = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    mut_mode;
  logic [PW-1:0] mut_prob;
  logic [CW-1:0] chrom_in;
  logic [CW-1:0] chrom_out;
  logic          ready;

  int vectors    = 0;
  int miscompares = 0;
  logic [SW-1:0] m_s;
  logic [TW-1:0] t_s;

  always #5 clk = ~clk;

  chrom_mutator #(
    .CHROM_W(CW), .PROB_W(PW),
    .MASK_POLY(MPOLY), .MASK_SEED(MSEED),
    .POINT_POLY(TPOLY), .POINT_SEED(TSEED)
  ) u_chrom_mutator (
    .clk(clk), .rst_n(rst_n), .start(start), .mut_mode(mut_mode),
    .mut_prob(mut_prob), .chrom_in(chrom_in), .chrom_out(chrom_out), .ready(ready)
  );

  function automatic logic [SW-1:0] m_next(input logic [SW-1:0] s);
    return (s >> 1) ^ (s[0] ? MPOLY : '0);
  endfunction

  function automatic logic [TW-1:0] t_next(input logic [TW-1:0] s);
    return (s >> 1) ^ (s[0] ? TPOLY : '0);
  endfunction

  function automatic logic [CW-1:0] predict(input logic [CW-1:0] x, input logic [1:0] md,
                                             input logic [PW-1:0] pm,
                                             input logic [SW-1:0] ms, input logic [TW-1:0] ts);
    logic [CW-1:0]   f;
    logic [2*SW-1:0] d;
    logic [PW-1:0]   w;
    f = '0;
    d = {ms, ms};
    if (ms[SW-1:CW] > pm) return x;
    case (md)
      2'b00: f[int'(ts) % CW] = 1'b1;
      2'b01: f = ms[CW-1:0];
      2'b10: for (int i = 0; i < CW; i++) begin
               w = PW'(d >> i);
               f[i] = (w <= pm);
             end
      default: f = '0;
    endcase
    return x ^ f;
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic request(input string tag, input logic [CW-1:0] x, input logic [1:0] md,
                         input logic [PW-1:0] pm, output logic [CW-1:0] got);
    logic [CW-1:0] exp;
    @(negedge clk);
    chrom_in = x; mut_mode = md; mut_prob = pm; start = 1'b1;
    exp = predict(x, md, pm, m_s, t_s);
    m_s = m_next(m_s); t_s = t_next(t_s);
    @(negedge clk);
    start = 1'b0;
    check({tag, " result"}, chrom_out, exp);
    check("R2 ready low after take", CW'(ready), '0);
    got = chrom_out;
    @(negedge clk);
    check("R2 ready back high", CW'(ready), CW'(1));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; mut_mode = 2'b00; mut_prob = '0; chrom_in = '0;
    m_s = MSEED; t_s = TSEED;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", CW'(ready), CW'(1));
    check("R1 output in reset", chrom_out, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", CW'(ready), CW'(1));
    check("R1 output after reset", chrom_out, '0);
  endtask

  task automatic t_copy();
    logic [CW-1:0] g;
    request("R3 copy mode", 16'hBEEF, 2'b11, 8'hFF, g);
    check("R3 copy equals input", g, 16'hBEEF);
  endtask

  task automatic t_single();
    logic [CW-1:0] g;
    for (int k = 0; k < 12; k++) begin
      request("R5 single-bit", 16'h1234 + 16'(k * 97), 2'b00, 8'hC0, g);
    end
  endtask

  task automatic t_masked();
    logic [CW-1:0] g;
    for (int k = 0; k < 10; k++) begin
      request("R6 masked", 16'hA5A5 ^ 16'(k * 331), 2'b01, 8'hFF, g);
    end
  endtask

  task automatic t_uniform();
    logic [CW-1:0] g;
    for (int k = 0; k < 12; k++) begin
      request("R7 uniform", 16'h0F0F + 16'(k * 77), 2'b10, 8'h80, g);
    end
  endtask

  task automatic t_full_prob();
    logic [CW-1:0] g;
    request("R9 uniform full prob", 16'h3C5A, 2'b10, 8'hFF, g);
    check("R9 all bits inverted", g, ~16'h3C5A);
  endtask

  task automatic t_zero_prob();
    logic [CW-1:0] g;
    for (int k = 0; k < 20; k++) begin
      request("R10 zero threshold", 16'h7E81 + 16'(k), 2'b01, 8'h00, g);
    end
    for (int k = 0; k < 6; k++) begin
      request("R4 gate high pr", 16'hC3C3 + 16'(k), 2'b00, 8'h10, g);
    end
  endtask

  task automatic t_held_start();
    logic [CW-1:0] e1;
    logic [CW-1:0] e2;
    @(negedge clk);
    chrom_in = 16'h1111; mut_mode = 2'b01; mut_prob = 8'hFF; start = 1'b1;
    e1 = predict(16'h1111, 2'b01, 8'hFF, m_s, t_s);
    m_s = m_next(m_s); t_s = t_next(t_s);
    @(negedge clk);
    check("R2 held start first take", chrom_out, e1);
    chrom_in = 16'h2222;
    e2 = predict(16'h2222, 2'b01, 8'hFF, m_s, t_s);
    @(negedge clk);
    check("R2 start ignored while settling", chrom_out, e1);
    check("R2 ready high after settle", CW'(ready), CW'(1));
    @(negedge clk);
    start = 1'b0;
    m_s = m_next(m_s); t_s = t_next(t_s);
    check("R8 single step per take", chrom_out, e2);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_copy();
    t_single();
    t_masked();
    t_uniform();
    t_full_prob();
    t_zero_prob();
    t_held_start();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule